// File: doc/BRIEF.md
# EDO DRAM Strobe Decoder with Refresh Counter

This block is the control front end of an extended-data-out DRAM device. It samples the row strobe, the two byte column strobes, the write enable and the output enable on every clock, finds their edges, and decides what kind of cycle the host is running. A row strobe edge while both column strobes are high opens a normal access. A column strobe edge inside that access then makes it a read or a write. If no column strobe falls, the access is a row-only refresh. A row strobe edge while a column strobe is already low is a counter-driven refresh. If read data is still being held at that point, the refresh is a hidden refresh.

The outputs drive a storage array that is not part of this block. They are a row address with a one-cycle activate pulse, a column address with per-byte read and write strobes, a data-output enable, and a cycle classification code. A 10-bit internal counter supplies the row for counter-driven refreshes. Read data stays enabled after the column strobe is released, and the enable drops only when all strobes are idle or output enable is deasserted.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, act_o, rd_stb_o, wr_stb_o and dq_oe_o are 0, cyc_o is 0 (idle) and the internal refresh counter is 0.
- R2: A sample with ras_ni low after a sample with it high, taken while ucas_ni and lcas_ni are both high, loads row_addr_o from addr_i and raises act_o for exactly one cycle. From the following cycle cyc_o is 3 (row-only refresh pending) until a column strobe falls.
- R3: Inside a normal access, col_addr_o follows addr_i one cycle later while both column strobes are high. It captures addr_i on a column strobe falling edge and holds it while a column strobe stays low.
- R4: A column strobe falling edge in a normal access with we_ni high pulses rd_stb_o for one cycle. Bit 0 is the lower byte (lcas_ni) and bit 1 is the upper byte (ucas_ni), and only the bytes whose strobe fell in that sample are set. cyc_o then becomes 1 (read).
- R5: The same edge with we_ni low pulses wr_stb_o with the same byte mapping, sets cyc_o to 2 (write) and leaves dq_oe_o at 0.
- R6: A row strobe falling edge while at least one column strobe is low and no read data is held loads row_addr_o from the refresh counter, pulses act_o, sets cyc_o to 4 and increments the counter. dq_oe_o stays 0 whatever oe_ni and we_ni are.
- R7: A row strobe falling edge while a column strobe is held low after a read sets cyc_o to 5 (hidden refresh), takes the row from the counter, increments it and keeps dq_oe_o at 1.
- R8: dq_oe_o is 1 from the cycle after a read column edge, and it stays 1 after the column strobes rise while ras_ni is low. It is 0 in the cycle after any sample with oe_ni high, or with ras_ni, ucas_ni and lcas_ni all high.
- R9: The refresh counter wraps from 1023 to 0.
- R10: cyc_o returns to 0 in the cycle after any sample with ras_ni high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ras_ni | input | 1 | Row strobe, active low |
| ucas_ni | input | 1 | Upper-byte column strobe, active low |
| lcas_ni | input | 1 | Lower-byte column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 10 | Multiplexed row/column address |
| row_addr_o | output | 10 | Row to activate |
| act_o | output | 1 | One-cycle row activate pulse |
| col_addr_o | output | 10 | Column address |
| rd_stb_o | output | 2 | Per-byte read strobe, bit 1 upper |
| wr_stb_o | output | 2 | Per-byte write strobe, bit 1 upper |
| dq_oe_o | output | 1 | Data output drive enable |
| cyc_o | output | 3 | Cycle type: 0 idle, 1 read, 2 write, 3 row-only, 4 counter refresh, 5 hidden refresh |

## Verification
A wrong refresh counter value shows on row_addr_o at the very next counter-driven refresh, one cycle after the row strobe edge. A stuck or lost held-read flag shows up in two ways. dq_oe_o drops too early in the extended-data window, or it stays high through an idle sample, and either one is visible one cycle later. A misclassified edge changes cyc_o, and it also puts strobes on the wrong byte or on the wrong read/write line, in the cycle right after the edge.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE   = 3'd0,
    CYC_READ   = 3'd1,
    CYC_WRITE  = 3'd2,
    CYC_RONLY  = 3'd3,
    CYC_CBR    = 3'd4,
    CYC_HIDDEN = 3'd5
  } cyc_e;

  typedef enum logic [1:0] {
    M_IDLE,
    M_ACCESS,
    M_REFRESH
  } mode_e;
endpackage

// File: rtl/dsc_edge.sv
module dsc_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b1;  // strobes idle high
      else         prev_q[g] <= sig_i[g];
    end
    assign fall_o[g] = prev_q[g] & ~sig_i[g];
    assign rise_o[g] = ~prev_q[g] & sig_i[g];
  end
endmodule

// File: rtl/dsc_ref_ctr.sv
module dsc_ref_ctr #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (step_i) cnt_o <= cnt_o + 1'b1;  // natural wrap
  end
endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned BYTES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              ucas_ni,
  input  logic              lcas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] row_addr_o,
  output logic              act_o,
  output logic [ADDR_W-1:0] col_addr_o,
  output logic [BYTES-1:0]  rd_stb_o,
  output logic [BYTES-1:0]  wr_stb_o,
  output logic              dq_oe_o,
  output logic [2:0]        cyc_o
);
  import dsc_pkg::*;

  localparam int unsigned NSTB = BYTES + 1;

  logic [NSTB-1:0]   stb, fall, rise;
  logic [BYTES-1:0]  cas_low, cas_fall;
  logic [ADDR_W-1:0] ref_cnt;
  logic              ras_fall, all_idle, ref_step;

  mode_e             mode_q, mode_d;
  cyc_e              cyc_q, cyc_d;
  logic              held_q, held_d;
  logic [ADDR_W-1:0] row_d, col_d;
  logic [BYTES-1:0]  rd_d, wr_d;
  logic              act_d, dq_oe_d;

  assign stb      = {ucas_ni, lcas_ni, ras_ni};
  assign ras_fall = fall[0];
  assign cas_fall = fall[NSTB-1:1];
  assign cas_low  = ~stb[NSTB-1:1];
  assign all_idle = &stb;

  dsc_edge #(.N(NSTB)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (stb),
    .fall_o (fall),
    .rise_o (rise)
  );

  dsc_ref_ctr #(.W(ADDR_W)) i_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (ref_step),
    .cnt_o  (ref_cnt)
  );

  always_comb begin
    mode_d   = mode_q;
    cyc_d    = cyc_q;
    held_d   = held_q;
    row_d    = row_addr_o;
    col_d    = col_addr_o;
    rd_d     = '0;
    wr_d     = '0;
    act_d    = 1'b0;
    ref_step = 1'b0;

    if (ras_ni) begin
      mode_d = M_IDLE;
      cyc_d  = CYC_IDLE;
    end

    if (ras_fall) begin
      act_d = 1'b1;
      if (|cas_low) begin
        // counter-driven refresh; hidden when read data still held
        row_d    = ref_cnt;
        ref_step = 1'b1;
        mode_d   = M_REFRESH;
        cyc_d    = held_q ? CYC_HIDDEN : CYC_CBR;
      end else begin
        row_d  = addr_i;
        mode_d = M_ACCESS;
        cyc_d  = CYC_RONLY;
        held_d = 1'b0;
      end
    end else if (mode_q == M_ACCESS && !ras_ni) begin
      if (|cas_fall) begin
        col_d = addr_i;
        if (!we_ni) begin
          wr_d   = cas_fall;
          cyc_d  = CYC_WRITE;
          held_d = 1'b0;
        end else begin
          rd_d   = cas_fall;
          cyc_d  = CYC_READ;
          held_d = 1'b1;
        end
      end else if (!(|cas_low)) begin
        col_d = addr_i;  // transparent column latch
      end
    end

    if (all_idle) held_d = 1'b0;
    dq_oe_d = held_d & ~oe_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= M_IDLE;
      cyc_q      <= CYC_IDLE;
      held_q     <= 1'b0;
      row_addr_o <= '0;
      col_addr_o <= '0;
      rd_stb_o   <= '0;
      wr_stb_o   <= '0;
      act_o      <= 1'b0;
      dq_oe_o    <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      cyc_q      <= cyc_d;
      held_q     <= held_d;
      row_addr_o <= row_d;
      col_addr_o <= col_d;
      rd_stb_o   <= rd_d;
      wr_stb_o   <= wr_d;
      act_o      <= act_d;
      dq_oe_o    <= dq_oe_d;
    end
  end

  assign cyc_o = cyc_q;

  logic unused_rise;
  assign unused_rise = ^rise;
endmodule

// File: rtl/dsc_chk.sv
module dsc_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned BYTES  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ras_ni,
  input logic              ucas_ni,
  input logic              lcas_ni,
  input logic              oe_ni,
  input logic [ADDR_W-1:0] row_addr_o,
  input logic              act_o,
  input logic [BYTES-1:0]  rd_stb_o,
  input logic [BYTES-1:0]  wr_stb_o,
  input logic              dq_oe_o,
  input logic [2:0]        cyc_o,
  input logic [ADDR_W-1:0] ref_cnt
);
  assert_act_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |=> !act_o);

  assert_act_after_ras_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |-> !$past(ras_ni));

  assert_rd_is_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rd_stb_o) |-> cyc_o == 3'd1);

  assert_wr_no_drive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_stb_o) |-> !dq_oe_o);

  assert_cbr_hiz_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_o == 3'd4 |-> !dq_oe_o);

  assert_ref_row_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && (cyc_o == 3'd4 || cyc_o == 3'd5)) |->
      (row_addr_o == $past(ref_cnt) && ref_cnt == ADDR_W'($past(ref_cnt) + 1'b1)));

  assert_idle_hiz_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ras_ni & ucas_ni & lcas_ni) |-> !dq_oe_o);

  assert_oe_hiz_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(oe_ni) |-> !dq_oe_o);

  assert_ras_high_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ras_ni) |-> cyc_o == 3'd0);
endmodule

bind dram_strobe_ctrl dsc_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) i_dsc_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ras_ni     (ras_ni),
  .ucas_ni    (ucas_ni),
  .lcas_ni    (lcas_ni),
  .oe_ni      (oe_ni),
  .row_addr_o (row_addr_o),
  .act_o      (act_o),
  .rd_stb_o   (rd_stb_o),
  .wr_stb_o   (wr_stb_o),
  .dq_oe_o    (dq_oe_o),
  .cyc_o      (cyc_o),
  .ref_cnt    (ref_cnt)
);

// File: tb/test_dram_strobe_ctrl.sv
module test_dram_strobe_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ras_ni = 1'b1, ucas_ni = 1'b1, lcas_ni = 1'b1;
  logic       we_ni = 1'b1, oe_ni = 1'b1;
  logic [9:0] addr_i = '0;
  logic [9:0] row_addr_o, col_addr_o;
  logic       act_o, dq_oe_o;
  logic [1:0] rd_stb_o, wr_stb_o;
  logic [2:0] cyc_o;

  int n_chk = 0, n_fail = 0, exp_ref = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  dram_strobe_ctrl i_dram_strobe_ctrl (.*);

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drv(logic r, logic u, logic l, logic w, logic o, logic [9:0] a);
    ras_ni = r; ucas_ni = u; lcas_ni = l; we_ni = w; oe_ni = o; addr_i = a;
  endtask

  task automatic t_reset();
    chk("R1 act", act_o, 0);
    chk("R1 dq_oe", dq_oe_o, 0);
    chk("R1 cyc", cyc_o, 0);
    chk("R1 strobes", {rd_stb_o, wr_stb_o}, 0);
  endtask

  task automatic t_read();
    drv(0, 1, 1, 1, 0, 10'h155); tick();
    chk("R2 act", act_o, 1);
    chk("R2 row", row_addr_o, 10'h155);
    chk("R2 cyc", cyc_o, 3);
    drv(0, 1, 1, 1, 0, 10'h0AA); tick();
    chk("R2 act single", act_o, 0);
    chk("R3 transparent col", col_addr_o, 10'h0AA);
    drv(0, 0, 0, 1, 0, 10'h0AA); tick();
    chk("R4 rd_stb", rd_stb_o, 2'b11);
    chk("R4 cyc", cyc_o, 1);
    chk("R8 dq on", dq_oe_o, 1);
    drv(0, 0, 0, 1, 0, 10'h3FF); tick();
    chk("R3 col held", col_addr_o, 10'h0AA);
    chk("R4 rd pulse", rd_stb_o, 0);
    drv(0, 1, 1, 1, 0, 10'h3FF); tick();
    chk("R8 edo hold", dq_oe_o, 1);
    drv(0, 1, 1, 1, 1, 10'h3FF); tick();
    chk("R8 oe high", dq_oe_o, 0);
    drv(0, 1, 1, 1, 0, 10'h3FF); tick();
    chk("R8 oe low again", dq_oe_o, 1);
    drv(1, 1, 1, 1, 0, 10'h000); tick();
    chk("R8 all idle", dq_oe_o, 0);
    chk("R10 cyc idle", cyc_o, 0);
  endtask

  task automatic t_write();
    drv(0, 1, 1, 1, 0, 10'h0F0); tick();
    drv(0, 1, 0, 0, 0, 10'h011); tick();
    chk("R5 wr_stb lower", wr_stb_o, 2'b01);
    chk("R5 no rd", rd_stb_o, 0);
    chk("R5 cyc", cyc_o, 2);
    chk("R5 dq off", dq_oe_o, 0);
    chk("R3 col", col_addr_o, 10'h011);
    drv(0, 0, 0, 0, 0, 10'h022); tick();
    chk("R5 wr_stb upper only", wr_stb_o, 2'b10);
    drv(1, 1, 1, 1, 1, 10'h000); tick();
  endtask

  task automatic t_ras_only();
    drv(0, 1, 1, 1, 0, 10'h222); tick();
    chk("R2 ras-only act", act_o, 1);
    chk("R2 ras-only row", row_addr_o, 10'h222);
    tick();
    chk("R2 ras-only cyc", cyc_o, 3);
    chk("R2 ras-only dq off", dq_oe_o, 0);
    drv(1, 1, 1, 1, 0, 10'h000); tick();
  endtask

  task automatic t_cbr(bit do_chk);
    drv(1, 0, 1, 0, 0, 10'h3C3); tick();
    drv(0, 0, 1, 0, 0, 10'h3C3); tick();
    if (do_chk) begin
      chk("R6 act", act_o, 1);
      chk("R6 row from counter", row_addr_o, exp_ref);
      chk("R6 cyc", cyc_o, 4);
      chk("R6 dq off", dq_oe_o, 0);
    end
    exp_ref = (exp_ref + 1) % 1024;
    drv(1, 1, 1, 1, 1, 10'h000); tick();
  endtask

  task automatic t_hidden();
    drv(0, 1, 1, 1, 0, 10'h033); tick();
    drv(0, 0, 0, 1, 0, 10'h044); tick();
    chk("R7 read dq", dq_oe_o, 1);
    drv(1, 0, 0, 1, 0, 10'h000); tick();
    chk("R7 dq while ras high", dq_oe_o, 1);
    chk("R10 cyc idle", cyc_o, 0);
    drv(0, 0, 0, 1, 0, 10'h000); tick();
    chk("R7 cyc", cyc_o, 5);
    chk("R7 act", act_o, 1);
    chk("R7 row", row_addr_o, exp_ref);
    chk("R7 dq kept", dq_oe_o, 1);
    chk("R7 no rd", rd_stb_o, 0);
    exp_ref = (exp_ref + 1) % 1024;
    drv(1, 1, 1, 1, 0, 10'h000); tick();
    chk("R8 idle after hidden", dq_oe_o, 0);
  endtask

  task automatic t_wrap();
    while (exp_ref != 1023) t_cbr(1'b0);
    t_cbr(1'b1);
    t_cbr(1'b1);  // R9: expects row 0 after 1023
    chk("R9 wrapped", exp_ref, 1);
  endtask

  task automatic t_mid_reset();
    drv(0, 1, 1, 1, 0, 10'h155); tick();
    drv(0, 0, 0, 1, 0, 10'h055); tick();
    rst_ni = 1'b0;
    #1;
    chk("R1 async dq", dq_oe_o, 0);
    chk("R1 async cyc", cyc_o, 0);
    drv(1, 1, 1, 1, 1, 10'h000); tick();
    rst_ni = 1'b1; tick();
    exp_ref = 0;
    t_cbr(1'b1);  // R1: counter restarted at 0
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_ni = 1'b1; tick();
    t_reset();
    t_read();
    t_write();
    t_ras_only();
    t_cbr(1'b1);
    t_cbr(1'b1);
    t_hidden();
    t_wrap();
    t_mid_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule